// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers up to 96 level-sensitive interrupt request lines into three banks of 32. Each line has a latched pending bit, an enable bit and a mask bit. The controller drives two processor request outputs. The normal request output is the OR of every pending source that is enabled, not masked and not steered to the fast path. The fast request output covers the sources that a build-time parameter steers to the fast path. A vector register names the lowest-numbered source that can be serviced. The number is scaled by four so that software can index a word-sized handler table with it, and a read of zero means there is no work.

Software uses a plain 32-bit register port: select, write enable, a privilege flag, a byte address, write data and registered read data. A handler reads the vector, services the source, and clears its pending bit by writing a one to it. Line 0 is a non-maskable style input. It never shows in the vector, and it has a selectable detection type: high level, low level, rising edge or falling edge. A protection bit restricts register access to privileged bus cycles.

The register port is a control path. It has no back-pressure: every selected cycle is accepted in the cycle it is presented.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every pending, enable and mask bit is 0, the protection bit and detection type are 0, irq_o and fiq_o are 0, and every register reads 0.
- R2: A source n that is high at a clock edge sets pending bit n%32 of bank n/32. Bank k's pending bits are read at byte address 0x10+4k.
- R3: A write of ones to 0x10+4k clears the matching pending bits, and zero bits leave them unchanged. If a source is still high in the cycle it is cleared, its pending bit stays set.
- R4: Enable bank k (0x40+4k, 1 = allowed) and mask bank k (0x50+4k, 1 = blocked) gate each pending bit. irq_o goes high one cycle after any pending, enabled, unmasked, non-fast source exists, and goes low one cycle after none is left.
- R5: A read of address 0x00 returns (n << 2), where n is the lowest-numbered serviceable source among 1..95 that is not steered to the fast path. It returns 0 if there is none. Source 0 never appears in the vector, although it can drive irq_o.
- R6: Sources selected by FIQ_ROUTE drive fiq_o instead of irq_o and are excluded from the vector. Address 0x20+4k reads bank k's pending bits ANDed with the routing. Writing ones there clears only the routed pending bits.
- R7: Bit 0 of address 0x08 is the protection bit. While it is 1, cycles with bus_priv low are refused: their writes change nothing, including the protection bit itself, and their reads return 0.
- R8: Bits [1:0] of address 0x0C choose how source 0 is detected: 0 = high level, 1 = low level, 2 = rising edge, 3 = falling edge. In the edge modes a source that stays in one state does not set the bit again after it is cleared.
- R9: bus_rdata shows the read result in the cycle after the read is presented and is 0 in any cycle that follows no read. Reads of unmapped, misaligned or nonexistent-bank addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Interrupt request lines, one per source |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupt pending, enable or mask bit shows at irq_o or fiq_o one cycle after it occurs. It also shows in the vector, or in the bank read, on the next register read. A wrong choice of priority shows only through the vector. The bench therefore puts several sources into competition and masks the winner to expose the runner-up. Errors in edge detection and protection are invisible until a clear or a refused write is followed by a read-back, so every such stimulus is followed at once by a read of the state it could have disturbed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned VEC_SHIFT = 2;

  // Region selector, bus_addr[7:4]
  localparam logic [3:0] RGN_CTRL = 4'h0;
  localparam logic [3:0] RGN_PEND = 4'h1;
  localparam logic [3:0] RGN_FIQ  = 4'h2;
  localparam logic [3:0] RGN_EN   = 4'h4;
  localparam logic [3:0] RGN_MASK = 4'h5;

  // Offsets inside the control region, bus_addr[3:0]
  localparam logic [3:0] OFS_VEC  = 4'h0;
  localparam logic [3:0] OFS_PROT = 4'h8;
  localparam logic [3:0] OFS_NMI  = 4'hC;

  typedef enum logic [1:0] {
    NMI_LVL_HI = 2'd0,
    NMI_LVL_LO = 2'd1,
    NMI_RISE   = 2'd2,
    NMI_FALL   = 2'd3
  } nmi_kind_e;
endpackage

// File: rtl/irqc_nmi_cond.sv
module irqc_nmi_cond
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw_i,
  input  nmi_kind_e kind_i,
  output logic      evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= raw_i;
  end

  always_comb begin
    unique case (kind_i)
      NMI_LVL_HI: evt_o = raw_i;
      NMI_LVL_LO: evt_o = ~raw_i;
      NMI_RISE:   evt_o = raw_i & ~prev_q;
      NMI_FALL:   evt_o = ~raw_i & prev_q;
      default:    evt_o = 1'b0;
    endcase
  end

  // R8: an edge event lasts a single cycle
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == NMI_RISE && evt_o) |=> (kind_i != NMI_RISE || !evt_o));

  // R8: a falling-edge event lasts a single cycle
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == NMI_FALL && evt_o) |=> (kind_i != NMI_FALL || !evt_o));
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] pend_q, en_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;
      if (en_we)   en_q   <= wdata_i;
      if (mask_we) mask_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;

  // R2
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/irqc_vector.sv
module irqc_vector #(
  parameter  int unsigned N  = 96,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Lowest index wins; index 0 is never reported
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [NUM_BANKS*BANK_W-1:0] FIQ_ROUTE = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic                        bus_priv,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [REG_W-1:0]            bus_wdata,
  output logic [REG_W-1:0]            bus_rdata,
  output logic                        irq_o,
  output logic                        fiq_o
);
  localparam int unsigned NSRC = NUM_BANKS * BANK_W;
  localparam int unsigned IDX_W = $clog2(NSRC);

  // ---------------- control state ----------------
  logic      prot_q;
  nmi_kind_e nmi_kind_q;
  logic      irq_q, fiq_q;
  logic [REG_W-1:0] rdata_q;

  // ---------------- bus decode ----------------
  logic [3:0] rgn, sub;
  logic [1:0] bsel;
  logic       aligned, access_ok, wr_ok, rd_req;

  assign rgn       = bus_addr[7:4];
  assign sub       = bus_addr[3:0];
  assign bsel      = bus_addr[3:2];
  assign aligned   = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:8] == '0 || ADDR_W == 8);
  assign access_ok = !prot_q || bus_priv;
  assign wr_ok     = bus_sel && bus_we && access_ok && aligned;
  assign rd_req    = bus_sel && !bus_we;

  // ---------------- source conditioning ----------------
  logic            nmi_evt;
  logic [NSRC-1:0] src_lv;

  irqc_nmi_cond u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (src_i[0]),
    .kind_i (nmi_kind_q),
    .evt_o  (nmi_evt)
  );

  assign src_lv = {src_i[NSRC-1:1], nmi_evt};

  // ---------------- banks ----------------
  logic [BANK_W-1:0] pend_bk  [NUM_BANKS];
  logic [BANK_W-1:0] en_bk    [NUM_BANKS];
  logic [BANK_W-1:0] mask_bk  [NUM_BANKS];
  logic [BANK_W-1:0] route_bk [NUM_BANKS];
  logic [NSRC-1:0]   pend_all, en_all, mask_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [1:0] BIDX = 2'(b);
    logic              hit;
    logic [BANK_W-1:0] clr;

    assign route_bk[b] = FIQ_ROUTE[b*BANK_W +: BANK_W];
    assign hit = wr_ok && (bsel == BIDX);
    assign clr = ((hit && rgn == RGN_PEND) ? bus_wdata : '0)
               | ((hit && rgn == RGN_FIQ)  ? (bus_wdata & route_bk[b]) : '0);

    irqc_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (src_lv[b*BANK_W +: BANK_W]),
      .clr_i   (clr),
      .en_we   (hit && rgn == RGN_EN),
      .mask_we (hit && rgn == RGN_MASK),
      .wdata_i (bus_wdata),
      .pend_o  (pend_bk[b]),
      .en_o    (en_bk[b]),
      .mask_o  (mask_bk[b])
    );

    assign pend_all[b*BANK_W +: BANK_W] = pend_bk[b];
    assign en_all  [b*BANK_W +: BANK_W] = en_bk[b];
    assign mask_all[b*BANK_W +: BANK_W] = mask_bk[b];
  end

  // ---------------- service logic ----------------
  logic [NSRC-1:0]  serv, serv_irq, serv_fiq;
  logic             vec_found;
  logic [IDX_W-1:0] vec_idx;

  assign serv     = pend_all & en_all & ~mask_all;
  assign serv_irq = serv & ~FIQ_ROUTE;
  assign serv_fiq = serv & FIQ_ROUTE;

  irqc_vector #(.N(NSRC)) u_vec (
    .req_i   (serv_irq),
    .found_o (vec_found),
    .idx_o   (vec_idx)
  );

  // ---------------- read mux ----------------
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (rgn)
        RGN_CTRL: begin
          if (sub == OFS_VEC && vec_found) rd_mux = REG_W'({vec_idx, 2'b00});
          else if (sub == OFS_PROT)        rd_mux = REG_W'(prot_q);
          else if (sub == OFS_NMI)         rd_mux = REG_W'(nmi_kind_q);
        end
        RGN_PEND: if (int'(bsel) < NUM_BANKS) rd_mux = REG_W'(pend_bk[bsel]);
        RGN_FIQ:  if (int'(bsel) < NUM_BANKS) rd_mux = REG_W'(pend_bk[bsel] & route_bk[bsel]);
        RGN_EN:   if (int'(bsel) < NUM_BANKS) rd_mux = REG_W'(en_bk[bsel]);
        RGN_MASK: if (int'(bsel) < NUM_BANKS) rd_mux = REG_W'(mask_bk[bsel]);
        default:  rd_mux = '0;
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q     <= 1'b0;
      nmi_kind_q <= NMI_LVL_HI;
      irq_q      <= 1'b0;
      fiq_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (wr_ok && rgn == RGN_CTRL && sub == OFS_PROT) prot_q <= bus_wdata[0];
      if (wr_ok && rgn == RGN_CTRL && sub == OFS_NMI)  nmi_kind_q <= nmi_kind_e'(bus_wdata[1:0]);
      irq_q   <= |serv_irq;
      fiq_q   <= |serv_fiq;
      rdata_q <= (rd_req && access_ok) ? rd_mux : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign fiq_o     = fiq_q;

  // ---------------- assertions ----------------
  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serv_irq != '0) |=> irq_o);

  // R4
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serv_irq == '0) |=> !irq_o);

  // R5
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_found |-> (serv_irq[vec_idx] && vec_idx != '0 &&
      ((serv_irq & ((NSRC'(1) << vec_idx) - NSRC'(1)) & ~NSRC'(1)) == '0)));

  // R6
  vec_not_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_found |-> !FIQ_ROUTE[vec_idx]);

  // R7
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && bus_sel && bus_we && !bus_priv) |=>
      ($stable(en_all) && $stable(mask_all) && $stable(prot_q) && $stable(nmi_kind_q)));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (bus_rdata == '0));
endmodule

// File: tb/test_irq_bank_ctrl.sv
`timescale 1ns/1ps
module test_irq_bank_ctrl;
  localparam int NSRC = 96;
  localparam logic [NSRC-1:0] FIQ_MAP = NSRC'(1) << 70;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            sel = 1'b0, we = 1'b0, priv = 1'b1;
  logic [7:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq, fiq;

  always #2.5 clk = ~clk;

  irq_bank_ctrl #(.FIQ_ROUTE(FIQ_MAP)) i_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel(sel), .bus_we(we), .bus_priv(priv), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fired = 1'b0;

  always @(posedge clk) rd_fired <= rst_n && sel && !we;

  always @(negedge clk) begin
    if (rd_fired) begin
      if (exp_q.size() == 0) check("R9 unexpected read", rdata, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic p = 1'b1);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d; priv = p;
    @(negedge clk); sel = 0; we = 0; priv = 1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag,
                    input logic p = 1'b1);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    sel = 1; we = 0; addr = a; priv = p;
    @(negedge clk); sel = 0; priv = 1;
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src[s] = 1'b1;
    @(negedge clk); src[s] = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 fiq after reset", {31'd0, fiq}, 32'd0);
    check("R1 rdata after reset", rdata, 32'd0);
    rd(8'h10, 32'h0, "R1 pending0");
    rd(8'h18, 32'h0, "R1 pending2");
    rd(8'h40, 32'h0, "R1 enable0");
    rd(8'h54, 32'h0, "R1 mask1");
    rd(8'h00, 32'h0, "R1 vector");
    rd(8'h0C, 32'h0, "R1 nmi type");

    // R2 latching
    pulse(5); pulse(40);
    rd(8'h10, 32'h20,  "R2 pending0 bit5");
    rd(8'h14, 32'h100, "R2 pending1 bit8");
    check("R4 irq gated by enable", {31'd0, irq}, 32'd0);

    // R4 / R5 enable and vector
    wr(8'h44, 32'h100); idle(1);
    check("R4 irq after enable", {31'd0, irq}, 32'd1);
    rd(8'h00, 32'd160, "R5 vector src40");
    wr(8'h40, 32'h20);
    rd(8'h00, 32'd20, "R5 vector lowest src5");
    wr(8'h50, 32'h20);
    rd(8'h00, 32'd160, "R4 mask hides src5");
    wr(8'h54, 32'h100); idle(1);
    check("R4 irq all masked", {31'd0, irq}, 32'd0);
    rd(8'h00, 32'd0, "R5 vector none");
    wr(8'h50, 32'h0); wr(8'h54, 32'h0);

    // R3 write-one-to-clear
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h20, "R3 zero write keeps");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R3 clear bank0");
    wr(8'h14, 32'h100); idle(1);
    rd(8'h14, 32'h0, "R3 clear bank1");
    check("R4 irq drops after clear", {31'd0, irq}, 32'd0);
    @(negedge clk); src[5] = 1'b1;
    wr(8'h10, 32'h20);
    rd(8'h10, 32'h20, "R3 held source re-sets");
    @(negedge clk); src[5] = 1'b0;
    wr(8'h10, 32'h20);
    rd(8'h10, 32'h0, "R3 released source clears");

    // R5 source 0 not in vector
    wr(8'h40, 32'h21);
    pulse(0); idle(1);
    check("R5 src0 drives irq", {31'd0, irq}, 32'd1);
    rd(8'h00, 32'd0, "R5 src0 not in vector");
    wr(8'h10, 32'h1);

    // R6 fast path
    wr(8'h48, 32'h40);
    pulse(70); idle(1);
    check("R6 fiq asserted", {31'd0, fiq}, 32'd1);
    check("R6 irq not from routed", {31'd0, irq}, 32'd0);
    rd(8'h00, 32'd0, "R6 routed not in vector");
    rd(8'h28, 32'h40, "R6 fast pending view");
    pulse(64);
    rd(8'h28, 32'h40, "R6 unrouted hidden in fast view");
    wr(8'h28, 32'hFFFF_FFFF); idle(1);
    check("R6 fiq drops", {31'd0, fiq}, 32'd0);
    rd(8'h18, 32'h1, "R6 fast clear spares unrouted");
    wr(8'h18, 32'hFFFF_FFFF);

    // R8 detection types for source 0
    wr(8'h0C, 32'h2);
    rd(8'h0C, 32'h2, "R8 type readback");
    @(negedge clk); src[0] = 1'b1;
    idle(3);
    rd(8'h10, 32'h1, "R8 rising sets");
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h0, "R8 rising held no re-set");
    @(negedge clk); src[0] = 1'b0;
    idle(2);
    rd(8'h10, 32'h0, "R8 rising ignores fall");
    wr(8'h0C, 32'h3);
    @(negedge clk); src[0] = 1'b1;
    idle(2);
    rd(8'h10, 32'h0, "R8 falling ignores rise");
    @(negedge clk); src[0] = 1'b0;
    idle(2);
    rd(8'h10, 32'h1, "R8 falling sets");
    wr(8'h0C, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h1, "R8 low level re-sets");
    wr(8'h0C, 32'h0);
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h0, "R8 high level idle");

    // R7 protection
    wr(8'h08, 32'h1);
    wr(8'h40, 32'hFFFF, 1'b0);
    rd(8'h40, 32'h21, "R7 unprivileged write ignored");
    rd(8'h40, 32'h0, "R7 unprivileged read zero", 1'b0);
    wr(8'h08, 32'h0, 1'b0);
    rd(8'h08, 32'h1, "R7 protection kept");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h0, "R7 privileged unprotect");

    // R9 read timing and unmapped space
    rd(8'h44, 32'h100, "R9 read data");
    idle(1);
    check("R9 rdata idle zero", rdata, 32'h0);
    rd(8'h30, 32'h0, "R9 unmapped");
    rd(8'h41, 32'h0, "R9 misaligned");
    rd(8'h4C, 32'h0, "R9 missing bank");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule